// File: doc/BRIEF.md
# Tone Burst and Pause Sequencer

This block times the gate that switches a dual-tone transmitter on and off. In timed mode, one strobe on the transmit-write input opens the tone gate for a fixed number of clock cycles. The gate then stays shut for a silent gap of the same length. After the gap, a ready flag rises to tell the controller that the next digit may be written. When the call-progress bit is set at the moment of the write, the tone and the gap both last twice as long.

In free-running mode the write strobe does nothing. The tone-enable bit opens and shuts the gate directly, so the tone can last as long as the controller chooses. The base length is set by a cycle-count parameter; its default is 51 ms at a 50 MHz clock. A bench can set it much smaller. Producing the waveform itself is left to the logic downstream of the gate.

Top module: `tone_burst_seq`

## Requirements
- R1: After reset, `tone_gate` is 0 and `tx_ready` is 1.
- R2: With `burst_n` = 0 (timed mode), a `tx_wr` pulse that is sampled while the block is idle drives `tone_gate` to 1 and `tx_ready` to 0 from the next cycle. `tone_gate` then stays at 1 for exactly L cycles.
- R3: Straight after the tone, `tone_gate` is 0 for exactly L cycles while `tx_ready` stays 0.
- R4: `tx_ready` returns to 1 in the cycle right after the gap, so it is 0 for exactly 2L cycles per write.
- R5: L = BURST_CYCLES when `cp_mode` is 0 at the accepted write, and L = 2·BURST_CYCLES when it is 1.
- R6: `cp_mode` is sampled only at the accepted write. Changing it during the tone or the gap does not change either length.
- R7: While a tone or a gap is running, further `tx_wr` pulses and changes of `tone_en` have no effect on `tone_gate` or `tx_ready`.
- R8: With `burst_n` = 1 (free-running mode), `tone_gate` equals `tone_en` delayed by one cycle, `tx_wr` is ignored and `tx_ready` stays 1.
- R9: A write issued in the first cycle in which `tx_ready` is back at 1 is accepted at once and starts a new tone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_wr | input | 1 | One-cycle strobe: transmit data written |
| burst_n | input | 1 | 0 selects timed tone/gap mode, 1 selects free-running mode |
| cp_mode | input | 1 | 1 doubles the tone and gap lengths (sampled at the write) |
| tone_en | input | 1 | Tone enable used in free-running mode |
| tone_gate | output | 1 | Registered gate that enables the tone generator |
| tx_ready | output | 1 | Registered flag: ready for a new digit |

## Verification
The bench runs timed writes with the call-progress bit both clear and set, and checks the gate and the ready flag cycle by cycle. This separates the single length from the doubled one, and the tone phase from the gap phase. It repeats each run while toggling the write strobe, the tone enable and the call-progress bit during the sequence; any one of these leaking into the timing shows up as a wrong phase length. It issues writes back to back, with idle gaps of zero to two cycles, to test acceptance in the first ready cycle. A bit pattern on the tone enable in free-running mode, with writes mixed in, shows the one-cycle follow and that the write strobe has no effect there.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_BURST = 2'd1,
    S_PAUSE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/tbs_len_sel.sv
module tbs_len_sel #(
  parameter int BURST_CYCLES = 2550000,
  parameter int CW           = 23
) (
  input  logic          cp_mode,
  output logic [CW-1:0] len_m1
);
  localparam logic [CW-1:0] SHORT_M1 = CW'(BURST_CYCLES - 1);
  localparam logic [CW-1:0] LONG_M1  = CW'(2 * BURST_CYCLES - 1);

  always_comb begin
    len_m1 = cp_mode ? LONG_M1 : SHORT_M1;
  end
endmodule

// File: rtl/tbs_timer.sv
module tbs_timer #(
  parameter int CW = 23
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // a decrement is only requested while time remains (R3)
  assert_timer_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
    (dec && !load) |-> !zero);
endmodule

// File: rtl/tone_burst_seq.sv
module tone_burst_seq #(
  parameter int BURST_CYCLES = 2550000
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_wr,
  input  logic burst_n,
  input  logic cp_mode,
  input  logic tone_en,
  output logic tone_gate,
  output logic tx_ready
);
  import tbs_pkg::*;

  localparam int CW = (2 * BURST_CYCLES > 1) ? $clog2(2 * BURST_CYCLES) : 1;

  seq_state_t    state, state_nx;
  logic [CW-1:0] sel_m1, len_q;
  logic          t_load, t_dec, t_zero;
  logic [CW-1:0] t_val;
  logic          gate_nx, ready_nx, start;

  tbs_len_sel #(.BURST_CYCLES(BURST_CYCLES), .CW(CW)) u_len (
    .cp_mode (cp_mode),
    .len_m1  (sel_m1)
  );

  tbs_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .dec      (t_dec),
    .zero     (t_zero)
  );

  assign start = (state == S_IDLE) && !burst_n && tx_wr;

  always_comb begin
    state_nx = state;
    gate_nx  = 1'b0;
    ready_nx = 1'b0;
    t_load   = 1'b0;
    t_dec    = 1'b0;
    t_val    = sel_m1;
    case (state)
      S_IDLE: begin
        if (start) begin
          state_nx = S_BURST;
          t_load   = 1'b1;
          gate_nx  = 1'b1;
          ready_nx = 1'b0;
        end else begin
          gate_nx  = burst_n & tone_en;
          ready_nx = 1'b1;
        end
      end
      S_BURST: begin
        if (t_zero) begin
          state_nx = S_PAUSE;
          t_load   = 1'b1;
          t_val    = len_q;
          gate_nx  = 1'b0;
        end else begin
          t_dec    = 1'b1;
          gate_nx  = 1'b1;
        end
      end
      S_PAUSE: begin
        if (t_zero) begin
          state_nx = S_IDLE;
          ready_nx = 1'b1;
        end else begin
          t_dec    = 1'b1;
        end
      end
      default: begin
        state_nx = S_IDLE;
        ready_nx = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      tone_gate <= 1'b0;
      tx_ready  <= 1'b1;
      len_q     <= '0;
    end else begin
      state     <= state_nx;
      tone_gate <= gate_nx;
      tx_ready  <= ready_nx;
      if (start) len_q <= sel_m1;
    end
  end

  // run-length checker: tone never longer than the doubled length
  logic [CW:0] gate_run;
  always_ff @(posedge clk) begin
    if (rst)                  gate_run <= '0;
    else if (state == S_BURST) gate_run <= gate_run + 1'b1;
    else                      gate_run <= '0;
  end

  assert_ready_fall_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_ready) |-> $past(tx_wr && !burst_n));

  assert_gap_silent_R3: assert property (@(posedge clk) disable iff (rst)
    (state == S_PAUSE) |-> (!tone_gate && !tx_ready));

  assert_ready_rise_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_ready) |-> $past(state == S_PAUSE));

  assert_burst_len_R5: assert property (@(posedge clk) disable iff (rst)
    gate_run <= (CW+1)'(2 * BURST_CYCLES));

  assert_len_held_R6: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE && $past(state) != S_IDLE) |-> $stable(len_q));

  assert_busy_ignores_R7: assert property (@(posedge clk) disable iff (rst)
    (state == S_BURST && !t_zero) |=> (state == S_BURST && tone_gate));

  assert_follow_R8: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && burst_n) |=> (tone_gate == $past(tone_en) && tx_ready));
endmodule

// File: tb/tone_burst_seq_bench.sv
module tone_burst_seq_bench;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst, tx_wr, burst_n, cp_mode, tone_en;
  logic tone_gate, tx_ready;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  tone_burst_seq #(.BURST_CYCLES(N)) u_tone_burst_seq (
    .clk(clk), .rst(rst), .tx_wr(tx_wr), .burst_n(burst_n),
    .cp_mode(cp_mode), .tone_en(tone_en),
    .tone_gate(tone_gate), .tx_ready(tx_ready)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // starts at a negedge; ends at the negedge of the first ready cycle
  task automatic run_burst(input logic cp, input bit disturb);
    int len;
    len = cp ? 2 * N : N;
    cp_mode = cp; burst_n = 1'b0; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    for (int i = 0; i < 2 * len; i++) begin
      if (i < len) begin
        chk(cp ? "R5" : "R2", "tone on", tone_gate, 1'b1);
        chk("R2", "ready low", tx_ready, 1'b0);
      end else begin
        chk(disturb ? "R7" : "R3", "gap silent", tone_gate, 1'b0);
        chk(disturb ? "R6" : "R3", "ready low in gap", tx_ready, 1'b0);
      end
      if (disturb) begin
        tx_wr   = i[0];
        tone_en = ~tone_en;
        cp_mode = ~cp_mode;
      end
      @(negedge clk);
    end
    tx_wr = 1'b0;
    cp_mode = cp;
    chk("R4", "ready back", tx_ready, 1'b1);
    chk("R4", "gate off", tone_gate, 1'b0);
  endtask

  initial begin
    rst = 1'b1; tx_wr = 1'b0; burst_n = 1'b0; cp_mode = 1'b0; tone_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "reset gate", tone_gate, 1'b0);
    chk("R1", "reset ready", tx_ready, 1'b1);

    // timed mode sweep: call-progress bit, disturbance, tone enable
    for (int cp = 0; cp < 2; cp++)
      for (int d = 0; d < 2; d++)
        for (int te = 0; te < 2; te++) begin
          tone_en = te[0];
          run_burst(cp[0], d[0]);
          @(negedge clk);
        end

    // back-to-back writes with idle gaps of 0..2 cycles (R9)
    for (int gap = 0; gap < 3; gap++)
      for (int cp = 0; cp < 2; cp++) begin
        run_burst(cp[0], 1'b0);
        repeat (gap) begin
          chk("R9", "idle gate", tone_gate, 1'b0);
          @(negedge clk);
        end
        run_burst(cp[0], 1'b0);
      end

    // free-running mode: gate follows tone_en one cycle later (R8)
    burst_n = 1'b1;
    for (int p = 0; p < 16; p++)
      for (int i = 0; i < 4; i++) begin
        tone_en = p[i];
        tx_wr   = (i == 1) || (p[0] && i == 3);
        @(negedge clk);
        chk("R8", "gate follows", tone_gate, p[i]);
        chk("R8", "ready held", tx_ready, 1'b1);
      end
    tx_wr = 1'b0; tone_en = 1'b0;
    @(negedge clk);
    chk("R8", "gate off", tone_gate, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule